// File: doc/BRIEF.md
# Programmable Parallel Port Core

This core drives 24 parallel I/O lines, arranged as three byte-wide ports: A, B and C. A host reaches it through four byte registers, one for each port and one for control, selected by a two-bit address. Writes to a port register load that port's output latch. Reads from a port register return either the latch or the live pins, depending on the port's direction.

The control register accepts two kinds of word, chosen by bit 7:

- **Mode word (bit 7 = 1).** Sets the direction of four groups: port A, port B, the upper nibble of C and the lower nibble of C. It also sets the operating-mode fields of group A and group B, which are brought out for a separate handshake block.
- **Bit command (bit 7 = 0).** Sets or clears one port C latch bit, leaving every other bit unchanged.

The core only implements simple latched I/O. Pads are driven outside the core through the per-line output and output-enable vectors.

Top module: `ppi_core`

## Requirements
- R1: After reset all output enables are low, the A and C latches are zero, both mode fields are zero, and a control read returns 0xFF.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register, for both reads and writes.
- R3: In a mode word, a direction bit of 1 makes its group an input (enables low) and 0 makes it an output (enables all high). The direction bits are: bit 4 for port A, bit 1 for port B, bit 3 for C[7:4] and bit 0 for C[3:0]. Examples: 0x80 makes every port an output, 0x90 makes A an input, and 0x82 makes B an input.
- R4: The two nibbles of port C follow their own direction bits independently. For example, 0x89 makes both nibbles inputs, 0x88 makes only the upper nibble an input, and 0x81 makes only the lower nibble an input.
- R5: A read of an input port, or of an input nibble of C, returns the pin values present in the same cycle, with no latching.
- R6: A read of an output port, or of an output nibble of C, returns the latch contents.
- R7: A mode-word write clears the A and C latches to zero in the next cycle and leaves the B latch unchanged.
- R8: In a bit command, bits 3..1 give the index of the C bit and bit 0 gives its new value. Only that latch bit changes. The directions and the control readback stay as they were. Examples: 0x0D sets C6, 0x09 sets C4, 0x05 sets C2 and 0x0C clears C6.
- R9: A control read returns the last mode word written.
- R10: The group A mode output equals bits 6..5 of the last mode word, and the group B mode output equals its bit 2.
- R11: A write to a port register updates that port's latch whatever its direction. The latch always appears on the port's output vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe for one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| pa_in | input | 8 | Port A pin values |
| pb_in | input | 8 | Port B pin values |
| pc_in | input | 8 | Port C pin values |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_oe | output | 8 | Port B output enables |
| pc_oe | output | 8 | Port C output enables |
| grp_a_mode | output | 2 | Group A operating mode |
| grp_b_mode | output | 1 | Group B operating mode |

## Verification
The assertions assume that the host presents at most one write per cycle, and that address and data are stable while the write strobe is high. They compare each latch one cycle after a write with the data of that write. The bench drives every write for exactly one clock, from a falling edge to the next falling edge, and changes the pin inputs only between clock edges. Reads are sampled shortly after a falling edge, so the combinational read path has settled before it is compared.

// File: rtl/ppi_core.sv
module ppi_core #(
  parameter logic [7:0] CFG_IDLE = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  input  logic [7:0] pb_in,
  input  logic [7:0] pc_in,
  output logic [7:0] pa_out,
  output logic [7:0] pb_out,
  output logic [7:0] pc_out,
  output logic [7:0] pa_oe,
  output logic [7:0] pb_oe,
  output logic [7:0] pc_oe,
  output logic [1:0] grp_a_mode,
  output logic       grp_b_mode
);
  localparam logic [1:0] OFS_A = 2'd0, OFS_B = 2'd1, OFS_C = 2'd2, OFS_CFG = 2'd3;

  logic [7:0] pa_q, pb_q, pc_q, cfg_rd_q;
  logic       a_in_q, b_in_q, chi_in_q, clo_in_q;
  logic [1:0] mode_a_q;
  logic       mode_b_q;
  logic       cfg_wr, mode_wr, bit_wr;

  assign cfg_wr  = wr_en && (addr == OFS_CFG);
  assign mode_wr = cfg_wr && wdata[7];
  assign bit_wr  = cfg_wr && !wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rd_q <= CFG_IDLE;
      a_in_q   <= 1'b1;
      b_in_q   <= 1'b1;
      chi_in_q <= 1'b1;
      clo_in_q <= 1'b1;
      mode_a_q <= 2'd0;
      mode_b_q <= 1'b0;
    end else if (mode_wr) begin
      cfg_rd_q <= wdata;
      mode_a_q <= wdata[6:5];
      a_in_q   <= wdata[4];
      chi_in_q <= wdata[3];
      mode_b_q <= wdata[2];
      b_in_q   <= wdata[1];
      clo_in_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
      pb_q <= '0;
      pc_q <= '0;
    end else begin
      if (mode_wr) begin
        pa_q <= '0;
        pc_q <= '0;
      end else if (bit_wr) begin
        pc_q[wdata[3:1]] <= wdata[0];
      end
      if (wr_en && addr == OFS_A) pa_q <= wdata;
      if (wr_en && addr == OFS_B) pb_q <= wdata;
      if (wr_en && addr == OFS_C) pc_q <= wdata;
    end
  end

  assign pa_out = pa_q;
  assign pb_out = pb_q;
  assign pc_out = pc_q;
  assign pa_oe  = {8{~a_in_q}};
  assign pb_oe  = {8{~b_in_q}};
  assign pc_oe  = {{4{~chi_in_q}}, {4{~clo_in_q}}};
  assign grp_a_mode = mode_a_q;
  assign grp_b_mode = mode_b_q;

  always_comb begin
    case (addr)
      OFS_A:   rdata = a_in_q ? pa_in : pa_q;
      OFS_B:   rdata = b_in_q ? pb_in : pb_q;
      OFS_C:   rdata = {chi_in_q ? pc_in[7:4] : pc_q[7:4],
                        clo_in_q ? pc_in[3:0] : pc_q[3:0]};
      default: rdata = cfg_rd_q;
    endcase
  end

  p_mode_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CFG && wdata[7]) |=> (pa_out == 8'h00 && pc_out == 8'h00 && $stable(pb_out)));

  p_bit_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CFG && !wdata[7]) |=> (pc_out[$past(wdata[3:1])] == $past(wdata[0])));

  p_bit_keeps_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CFG && !wdata[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(cfg_rd_q)));

  p_port_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_A) |=> (pa_out == $past(wdata)));

  p_mode_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CFG && wdata[7]) |=> (grp_a_mode == $past(wdata[6:5]) && grp_b_mode == $past(wdata[2])));
endmodule

// File: tb/ppi_core_tb.sv
module ppi_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe;
  logic [1:0] grp_a_mode;
  logic       grp_b_mode;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ppi_core u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
    .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
    .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe),
    .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    check("R1 pc_out", pc_out, 8'h00);
    check("R1 modes", {5'd0, grp_a_mode, grp_b_mode}, 8'h00);
    rd(2'd3, v); check("R1 cfg read", v, 8'hFF);
  endtask

  task automatic t_dirs;
    logic [7:0] v;
    wr(2'd3, 8'h80);
    check("R3 0x80 pa_oe", pa_oe, 8'hFF);
    check("R3 0x80 pb_oe", pb_oe, 8'hFF);
    check("R3 0x80 pc_oe", pc_oe, 8'hFF);
    rd(2'd3, v); check("R9 cfg 0x80", v, 8'h80);
    wr(2'd3, 8'h90);
    check("R3 0x90 pa_oe", pa_oe, 8'h00);
    check("R3 0x90 pb_oe", pb_oe, 8'hFF);
    wr(2'd3, 8'h82);
    check("R3 0x82 pb_oe", pb_oe, 8'h00);
    check("R3 0x82 pa_oe", pa_oe, 8'hFF);
    wr(2'd3, 8'h89);
    check("R4 0x89 pc_oe", pc_oe, 8'h00);
    check("R4 0x89 pa_oe", pa_oe, 8'hFF);
    wr(2'd3, 8'h88);
    check("R4 0x88 pc_oe", pc_oe, 8'h0F);
    wr(2'd3, 8'h81);
    check("R4 0x81 pc_oe", pc_oe, 8'hF0);
    rd(2'd3, v); check("R9 cfg 0x81", v, 8'h81);
  endtask

  task automatic t_out_readback;
    logic [7:0] v;
    wr(2'd3, 8'h80);
    pa_in = 8'h11; pb_in = 8'h22; pc_in = 8'h33;
    wr(2'd0, 8'h5A); wr(2'd1, 8'hC3); wr(2'd2, 8'h96);
    rd(2'd0, v); check("R6 R2 read A", v, 8'h5A);
    rd(2'd1, v); check("R6 R2 read B", v, 8'hC3);
    rd(2'd2, v); check("R6 R2 read C", v, 8'h96);
    check("R11 pa_out", pa_out, 8'h5A);
    check("R11 pb_out", pb_out, 8'hC3);
    check("R11 pc_out", pc_out, 8'h96);
  endtask

  task automatic t_in_live;
    logic [7:0] v;
    wr(2'd3, 8'h9B);
    pa_in = 8'hA1; pb_in = 8'hB2; pc_in = 8'hC3;
    rd(2'd0, v); check("R5 read A pins", v, 8'hA1);
    rd(2'd1, v); check("R5 read B pins", v, 8'hB2);
    rd(2'd2, v); check("R5 read C pins", v, 8'hC3);
    pb_in = 8'h4E;
    rd(2'd1, v); check("R5 live B change", v, 8'h4E);
    wr(2'd3, 8'h88);
    pc_in = 8'hA5;
    wr(2'd2, 8'h3C);
    rd(2'd2, v); check("R4 R6 mixed C", v, 8'hAC);
    wr(2'd3, 8'h81);
    wr(2'd2, 8'h3C);
    rd(2'd2, v); check("R4 R6 mixed C low in", v, 8'h35);
  endtask

  task automatic t_mode_clear;
    wr(2'd3, 8'h80);
    wr(2'd0, 8'hFF); wr(2'd1, 8'h77); wr(2'd2, 8'hFF);
    wr(2'd3, 8'h80);
    check("R7 A cleared", pa_out, 8'h00);
    check("R7 C cleared", pc_out, 8'h00);
    check("R7 B kept", pb_out, 8'h77);
  endtask

  task automatic t_bitcmd;
    logic [7:0] v;
    wr(2'd3, 8'h80);
    wr(2'd3, 8'h0D); check("R8 set C6", pc_out, 8'h40);
    wr(2'd3, 8'h09); check("R8 set C4", pc_out, 8'h50);
    wr(2'd3, 8'h05); check("R8 set C2", pc_out, 8'h54);
    wr(2'd3, 8'h0C); check("R8 clear C6", pc_out, 8'h14);
    wr(2'd3, 8'h01); check("R8 set C0", pc_out, 8'h15);
    rd(2'd3, v); check("R8 cfg kept", v, 8'h80);
    check("R8 pc_oe kept", pc_oe, 8'hFF);
    wr(2'd3, 8'h89);
    pc_in = 8'h5A;
    wr(2'd3, 8'h0F); check("R8 set C7 input", pc_out, 8'h80);
    rd(2'd2, v); check("R8 R5 read C pins", v, 8'h5A);
    check("R8 pc_oe input kept", pc_oe, 8'h00);
  endtask

  task automatic t_modes;
    logic [7:0] v;
    wr(2'd3, 8'hC4);
    check("R10 mode a=2", {6'd0, grp_a_mode}, 8'h02);
    check("R10 mode b=1", {7'd0, grp_b_mode}, 8'h01);
    rd(2'd3, v); check("R9 cfg 0xC4", v, 8'hC4);
    wr(2'd3, 8'hA0);
    check("R10 mode a=1", {6'd0, grp_a_mode}, 8'h01);
    check("R10 mode b=0", {7'd0, grp_b_mode}, 8'h00);
  endtask

  task automatic t_write_input;
    logic [7:0] v;
    wr(2'd3, 8'h9B);
    pa_in = 8'hE7;
    wr(2'd0, 8'h33);
    check("R11 latch on input", pa_out, 8'h33);
    check("R11 oe low", pa_oe, 8'h00);
    rd(2'd0, v); check("R11 R5 read pins", v, 8'hE7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_dirs();
    t_out_readback();
    t_in_live();
    t_mode_clear();
    t_bitcmd();
    t_modes();
    t_write_input();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule